// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This controller lets a clocked on-chip client read and write one byte-wide external static RAM that has no clock of its own. The client presents an address, a write flag and write data while `req_ready` is high. The controller then drives the RAM address, chip enable, write enable and output enable, plus a split data bus with separate output, output-enable and input parts, for as many clock cycles as the RAM's nanosecond limits require. A read returns its byte with a single-cycle `rsp_valid` pulse.

All cycle counts come from parameters. Each nanosecond limit is divided by the clock period and rounded up, and no count is less than one cycle. The fast grade is the default set. The slower grade is chosen by overriding the limit parameters. Writes end on the rising edge of write enable, and output enable stays low while write enable is low. Because of this, the controller does not drive write data until the RAM has had time to release the bus, and that wait is counted inside the write cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: A read holds chip enable and output enable low and write enable high from the acceptance edge. The byte on `sram_dq_in` is sampled AA cycles after acceptance, where AA = ceil(access time / period). It is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R2: A write lowers write enable, chip enable and output enable on the acceptance edge. Write enable stays low for WEL = max(ceil(pulse width), ceil(turn-off) + ceil(data setup)) cycles.
- R3: Write data is driven (`sram_dq_oe` = 1) starting HZ = ceil(turn-off / period) cycles after write enable falls. It stays driven through the cycle in which write enable rises, which gives at least ceil(setup) cycles of setup and one cycle of hold.
- R4: `req_ready` falls on the acceptance edge. A read allows the next acceptance RCY = max(ceil(read cycle), AA, 2) cycles after the previous one, and a write allows it WCY = max(ceil(write cycle), WEL + 2) cycles after. `req_ready` is high in the cycle before that.
- R5: A request offered while `req_ready` is low has no effect on the RAM pins or the RAM contents.
- R6: The controller never drives the data bus while chip enable and output enable are low and write enable is high. The bus is released at least one cycle before output enable falls.
- R7: During reset and whenever idle, chip enable, write enable and output enable are high, the bus is released, `req_ready` is high and `rsp_valid` is low.
- R8: Each limit converts to ceil(ns / period) cycles with a floor of one. With a 10 ns clock and the default limits this gives HZ = 2, WEL = 5, WCY = 7, AA = 6 and RCY = 6.
- R9: `sram_addr` takes the request address on the acceptance edge and does not change until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read byte |
| sram_addr | output | ADDR_W | RAM address |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | DATA_W | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | DATA_W | Data from the RAM |

## Verification
The bench goes after the places where an off-by-one in the cycle counts matters. It checks the first and last drive cycle of write data against the write enable edges, because driving one cycle early collides with the RAM's outputs and releasing early breaks setup. It checks a read that directly follows a write, where a controller that kept the bus driven as output enable fell would short two drivers. It checks a request offered while busy, where a controller that latched it would corrupt a second address. It also checks back-to-back requests held valid, where a wrong ready timing would shorten the cycle below the RAM minimum or add a dead cycle, and it checks the first and last addresses of the array.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned r;
    r = (ns + per - 1) / per;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_HZ  = 2,
  parameter int unsigned N_WEL = 5,
  parameter int unsigned N_WCY = 7,
  parameter int unsigned N_AA  = 6,
  parameter int unsigned N_RCY = 6,
  parameter int unsigned CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  input  logic is_write_i,
  output logic ready_o,
  output logic ev_dq_on_o,
  output logic ev_we_end_o,
  output logic ev_dq_off_o,
  output logic ev_capture_o,
  output logic ev_done_o
);

  localparam logic [CNT_W-1:0] C_DQ_ON  = CNT_W'(N_HZ - 1);
  localparam logic [CNT_W-1:0] C_WE_END = CNT_W'(N_WEL - 1);
  localparam logic [CNT_W-1:0] C_DQ_OFF = CNT_W'(N_WEL);
  localparam logic [CNT_W-1:0] C_W_RDY  = CNT_W'(N_WCY - 2);
  localparam logic [CNT_W-1:0] C_W_DONE = CNT_W'(N_WCY - 1);
  localparam logic [CNT_W-1:0] C_CAP    = CNT_W'(N_AA - 1);
  localparam logic [CNT_W-1:0] C_R_RDY  = CNT_W'(N_RCY - 2);
  localparam logic [CNT_W-1:0] C_R_DONE = CNT_W'(N_RCY - 1);

  sram_op_e         op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_wr, in_rd, ev_ready;

  assign in_wr = (op_q == OP_WRITE);
  assign in_rd = (op_q == OP_READ);

  always_comb begin
    ev_dq_on_o   = in_wr && (cnt_q == C_DQ_ON);
    ev_we_end_o  = in_wr && (cnt_q == C_WE_END);
    ev_dq_off_o  = in_wr && (cnt_q == C_DQ_OFF);
    ev_capture_o = in_rd && (cnt_q == C_CAP);
    ev_ready     = (in_wr && (cnt_q == C_W_RDY))  || (in_rd && (cnt_q == C_R_RDY));
    ev_done_o    = (in_wr && (cnt_q == C_W_DONE)) || (in_rd && (cnt_q == C_R_DONE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_IDLE;
      cnt_q   <= '0;
      ready_o <= 1'b1;
    end else if (accept_i) begin
      op_q    <= is_write_i ? OP_WRITE : OP_READ;
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (op_q != OP_IDLE) begin
      if (ev_done_o) begin
        op_q  <= OP_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (ev_ready) ready_o <= 1'b1;
    end
  end

endmodule

// File: rtl/sram_pins.sv
module sram_pins #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ev_dq_on_i,
  input  logic              ev_we_end_i,
  input  logic              ev_dq_off_i,
  input  logic              ev_done_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [DATA_W-1:0] dq_out_o,
  output logic              dq_oe_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr_o <= '0;
      ce_n_o      <= 1'b1;
      we_n_o      <= 1'b1;
      oe_n_o      <= 1'b1;
      dq_out_o    <= '0;
      dq_oe_o     <= 1'b0;
    end else if (accept_i) begin
      sram_addr_o <= addr_i;
      ce_n_o      <= 1'b0;
      oe_n_o      <= 1'b0;
      we_n_o      <= ~is_write_i;
      dq_oe_o     <= 1'b0;
      if (is_write_i) dq_out_o <= wdata_i;
    end else begin
      if (ev_dq_on_i)  dq_oe_o <= 1'b1;
      if (ev_dq_off_i) dq_oe_o <= 1'b0;
      if (ev_we_end_i) begin
        we_n_o <= 1'b1;
        oe_n_o <= 1'b1;
      end
      if (ev_done_i) begin
        ce_n_o <= 1'b1;
        oe_n_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_in_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= capture_i;
      if (capture_i) rsp_rdata_o <= dq_in_i;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_PWE_NS      = 45,
  parameter int unsigned T_SD_NS       = 25,
  parameter int unsigned T_HZWE_NS     = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned N_HZ  = ns_to_cyc(T_HZWE_NS, CLK_PERIOD_NS);
  localparam int unsigned N_SD  = ns_to_cyc(T_SD_NS,   CLK_PERIOD_NS);
  localparam int unsigned N_PWE = ns_to_cyc(T_PWE_NS,  CLK_PERIOD_NS);
  localparam int unsigned N_WC  = ns_to_cyc(T_WC_NS,   CLK_PERIOD_NS);
  localparam int unsigned N_RC  = ns_to_cyc(T_RC_NS,   CLK_PERIOD_NS);
  localparam int unsigned N_AA  = ns_to_cyc(T_AA_NS,   CLK_PERIOD_NS);
  localparam int unsigned N_WEL = umax(N_PWE, N_HZ + N_SD);
  localparam int unsigned N_WCY = umax(N_WC, N_WEL + 2);
  localparam int unsigned N_RCY = umax(umax(N_RC, N_AA), 2);
  localparam int unsigned CNT_W = $clog2(umax(N_WCY, N_RCY) + 1);

  logic accept;
  logic ev_dq_on, ev_we_end, ev_dq_off, ev_capture, ev_done;

  assign accept = req_valid && req_ready;

  sram_seq #(
    .N_HZ(N_HZ), .N_WEL(N_WEL), .N_WCY(N_WCY),
    .N_AA(N_AA), .N_RCY(N_RCY), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .accept_i(accept), .is_write_i(req_write),
    .ready_o(req_ready),
    .ev_dq_on_o(ev_dq_on), .ev_we_end_o(ev_we_end), .ev_dq_off_o(ev_dq_off),
    .ev_capture_o(ev_capture), .ev_done_o(ev_done)
  );

  sram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst),
    .accept_i(accept), .is_write_i(req_write),
    .addr_i(req_addr), .wdata_i(req_wdata),
    .ev_dq_on_i(ev_dq_on), .ev_we_end_i(ev_we_end),
    .ev_dq_off_i(ev_dq_off), .ev_done_i(ev_done),
    .sram_addr_o(sram_addr), .ce_n_o(sram_ce_n), .we_n_o(sram_we_n),
    .oe_n_o(sram_oe_n), .dq_out_o(sram_dq_out), .dq_oe_o(sram_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst),
    .capture_i(ev_capture), .dq_in_i(sram_dq_in),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
  );

endmodule

// File: rtl/sram_ctrl_checks.sv
module sram_ctrl_checks
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_PWE_NS      = 45,
  parameter int unsigned T_SD_NS       = 25,
  parameter int unsigned T_HZWE_NS     = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  localparam int unsigned K_HZ  = ns_to_cyc(T_HZWE_NS, CLK_PERIOD_NS);
  localparam int unsigned K_SD  = ns_to_cyc(T_SD_NS,   CLK_PERIOD_NS);
  localparam int unsigned K_WEL = umax(ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS), K_HZ + K_SD);

  logic [15:0] we_low_cnt, setup_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt <= '0;
      setup_cnt  <= '0;
    end else begin
      we_low_cnt <= sram_we_n ? 16'd0 : we_low_cnt + 16'd1;
      setup_cnt  <= sram_we_n ? 16'd0 : (sram_dq_oe ? setup_cnt + 16'd1 : setup_cnt);
    end
  end

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R1
  AST_WE_UNDER_CE_OE: assert property (@(posedge clk) disable iff (rst) !sram_we_n |-> (!sram_ce_n && !sram_oe_n)); // R2
  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (rst) $rose(sram_we_n) |-> (we_low_cnt >= 16'(K_WEL))); // R2
  AST_DRIVE_AFTER_HZ: assert property (@(posedge clk) disable iff (rst) $rose(sram_dq_oe) |-> (!sram_we_n && we_low_cnt >= 16'(K_HZ))); // R3
  AST_SETUP_MIN: assert property (@(posedge clk) disable iff (rst) $rose(sram_we_n) |-> (setup_cnt >= 16'(K_SD))); // R3
  AST_HOLD_AT_END: assert property (@(posedge clk) disable iff (rst) $rose(sram_we_n) |-> sram_dq_oe); // R3
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst) !(sram_dq_oe && !sram_ce_n && !sram_oe_n && sram_we_n)); // R6
  AST_RELEASE_BEFORE_OE: assert property (@(posedge clk) disable iff (rst) $fell(sram_oe_n) |-> !$past(sram_dq_oe)); // R6
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) sram_ce_n |-> (!sram_dq_oe && sram_we_n)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) !(req_valid && req_ready) |=> $stable(sram_addr)); // R9

endmodule

bind sram_async_ctrl sram_ctrl_checks #(
  .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_PWE_NS(T_PWE_NS), .T_SD_NS(T_SD_NS), .T_HZWE_NS(T_HZWE_NS)
) u_checks (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
  .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int PER = 10;
  function automatic int cyc(input int ns);
    int r;
    r = (ns + PER - 1) / PER;
    return (r < 1) ? 1 : r;
  endfunction
  localparam int HZ  = cyc(20);
  localparam int SD  = cyc(25);
  localparam int PWE = cyc(45);
  localparam int AA  = cyc(55);
  localparam int WEL = (PWE > HZ + SD) ? PWE : HZ + SD;
  localparam int WCY = (cyc(55) > WEL + 2) ? cyc(55) : WEL + 2;
  localparam int RCY = (cyc(55) > AA) ? cyc(55) : AA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [18:0] sram_addr;
  logic sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0] sram_dq_out, sram_dq_in;

  always #5 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // Behavioural RAM: a write lands when write enable rises during select.
  logic [7:0] mem [int];
  logic [7:0] rd_byte = 8'h00;
  always @(posedge sram_we_n)
    if (sram_ce_n === 1'b0 && sram_dq_oe === 1'b1) mem[int'(sram_addr)] = sram_dq_out;
  always @(negedge clk)
    rd_byte <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? rd_byte : 8'h00;

  int checks = 0, fails = 0;
  int conflicts = 0, late_release = 0;
  logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sram_dq_oe && !sram_ce_n && !sram_oe_n && sram_we_n) conflicts++;
      if (prev_oe_n && !sram_oe_n && prev_dq_oe) late_release++;
    end
    prev_oe_n  <= sram_oe_n;
    prev_dq_oe <= sram_dq_oe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R7", "enables high after reset",
        {sram_ce_n, sram_we_n, sram_oe_n}, 7);
    chk(!sram_dq_oe && req_ready && !rsp_valid, "R7", "bus/ready/rsp after reset",
        {sram_dq_oe, req_ready, rsp_valid}, 2);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int we_low = 0, first_dq = -1, last_dq = -1, first_rdy = -1, oe_bad = 0;
    logic addr_ok;
    issue(1'b1, a, d);
    addr_ok = (sram_addr == a);
    for (int k = 0; k <= WCY; k++) begin
      if (k > 0) @(negedge clk);
      if (k < WCY) begin
        if (!sram_we_n) begin
          we_low++;
          if (sram_oe_n || sram_ce_n) oe_bad++;
        end
        if (sram_dq_oe) begin
          if (first_dq < 0) first_dq = k;
          last_dq = k;
        end
        if (req_ready && first_rdy < 0) first_rdy = k;
      end else begin
        chk(sram_ce_n && !sram_dq_oe, "R7", "idle after write", {sram_ce_n, sram_dq_oe}, 2);
      end
    end
    chk(we_low == WEL, "R2", "write enable low cycles (R8 count)", we_low, WEL);
    chk(oe_bad == 0, "R2", "ce/oe low during write pulse", oe_bad, 0);
    chk(first_dq == HZ, "R3", "first drive cycle", first_dq, HZ);
    chk(last_dq == WEL, "R3", "last drive cycle", last_dq, WEL);
    chk(first_rdy == WCY - 1, "R4", "write ready cycle", first_rdy, WCY - 1);
    chk(addr_ok, "R9", "write address on pins", int'(sram_addr), int'(a));
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] exp);
    int pulses = 0, pulse_k = -1, first_rdy = -1, bad_ctl = 0, addr_bad = 0;
    logic [7:0] got = 8'h00;
    issue(1'b0, a, 8'h00);
    for (int k = 0; k <= RCY; k++) begin
      if (k > 0) @(negedge clk);
      if (rsp_valid) begin pulses++; pulse_k = k; got = rsp_rdata; end
      if (k < RCY) begin
        if (sram_ce_n || sram_oe_n || !sram_we_n || sram_dq_oe) bad_ctl++;
        if (sram_addr != a) addr_bad++;
        if (req_ready && first_rdy < 0) first_rdy = k;
      end else begin
        chk(sram_ce_n && sram_oe_n, "R7", "idle after read", {sram_ce_n, sram_oe_n}, 3);
      end
    end
    chk(pulses == 1 && pulse_k == AA, "R1", "response pulse cycle", pulse_k, AA);
    chk(got == exp, "R1", "read data", int'(got), int'(exp));
    chk(bad_ctl == 0, "R1", "read enables", bad_ctl, 0);
    chk(addr_bad == 0, "R9", "address held during read", addr_bad, 0);
    chk(first_rdy == RCY - 1, "R4", "read ready cycle", first_rdy, RCY - 1);
  endtask

  task automatic t_back_to_back(input logic [18:0] a);
    int idx [$];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    for (int n = 0; n < 2 * RCY + 1; n++) begin
      if (req_ready) idx.push_back(n);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(idx.size() >= 2 && (idx[1] - idx[0]) == RCY, "R4", "back-to-back spacing",
        (idx.size() >= 2) ? idx[1] - idx[0] : -1, RCY);
    repeat (RCY + 2) @(negedge clk);
  endtask

  task automatic t_ignored(input logic [18:0] ra, input logic [18:0] wa);
    int busy_bad = 0;
    issue(1'b0, ra, 8'h00);
    req_valid = 1'b1; req_write = 1'b1; req_addr = wa; req_wdata = 8'h5A;
    for (int k = 1; k <= RCY - 2; k++) begin
      @(negedge clk);
      if (!sram_we_n || sram_addr != ra) busy_bad++;
    end
    req_valid = 1'b0;
    chk(busy_bad == 0, "R5", "pins untouched by busy request", busy_bad, 0);
    repeat (RCY + 1) @(negedge clk);
  endtask

  initial begin
    #(200000 * PER);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(19'h00123, 8'hA5);
    t_read(19'h00123, 8'hA5);
    t_write(19'h00000, 8'h3C);
    t_write(19'h7FFFF, 8'hC3);
    t_read(19'h00000, 8'h3C);
    t_read(19'h7FFFF, 8'hC3);
    t_write(19'h00055, 8'h11);
    t_back_to_back(19'h00123);
    t_ignored(19'h00123, 19'h00055);
    t_read(19'h00055, 8'h11);
    chk(conflicts == 0, "R6", "bus contention cycles", conflicts, 0);
    chk(late_release == 0, "R6", "bus driven when oe fell", late_release, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule